// File: doc/BRIEF.md
# Sigma-Delta Decimation Pipeline

This block turns an oversampled input stream into signed 24-bit samples. The input is either a 1-bit sigma-delta bitstream or a signed 24-bit parallel sample stream, and each input item arrives with a one-cycle valid strobe. A sinc filter of order 1 to 5, or a fast second-order variant, decimates the stream by a programmable ratio. A following accumulator then sums a programmable number of decimated filter outputs. The 32-bit sum is arithmetically right-shifted and cut to 24 bits. Parallel samples can also skip the filter and go straight to the accumulator.

Every conversion begins with a start pulse, which clears the filter and accumulator state. In one-shot mode the block counts input strobes until the whole settling span has passed, then presents exactly one result. In continuous mode it keeps producing results once the filter has settled. All internal arithmetic is 32-bit two's complement and wraps on overflow. The configuration must stay stable from the start pulse to the end of the conversion.

Top module: `sd_decim`

## Requirements
- R1: A serial bit of 1 enters the filter as +1 and a bit of 0 enters as −1. In one-shot mode with sinc order N (order_i = N, 1..5), decimation ratio D and accumulation count K, a constant input c gives the result c·K·D^N.
- R2: In one-shot sinc mode, the input strobe that completes the conversion is number D·(K−1+N)+(N+1), counted from the start pulse. sample_valid_o is high in the cycle after the third rising clock edge following the edge that samples that strobe.
- R3: With fastsinc_i = 1, the filter computes second order whatever order_i says. The one-shot conversion completes on strobe D·(K+3)+3, and a constant input c gives c·K·D².
- R4: In continuous mode (cont_i = 1) with a filtered input, the first result completes on strobe D·(S+K), where S = N−1 for sinc and S = 3 for fastsinc. Later results complete every D·K strobes. Output timing follows R2.
- R5: With src_par_i = 1 and bypass_i = 0, the signed 24-bit par_data_i is sign-extended and filtered in the same way as serial data, with par_valid_i as the strobe.
- R6: With src_par_i = 1 and bypass_i = 1, each result is the sum of K consecutive parallel samples and completes on the K-th one. One-shot mode gives one such result, and continuous mode repeats it without losing a sample that arrives in the capture cycle.
- R7: sample_o is bits 23:0 of the 32-bit sum arithmetically shifted right by shift_i (0..31). A sum beyond 24 bits wraps, and a shift of 31 yields all zeros or all ones.
- R8: sample_valid_o is a one-cycle pulse in one-shot mode, and sample_o holds its value whenever sample_valid_o is low.
- R9: No result appears after reset until a start pulse has been given. One-shot mode yields exactly one result per start, and further strobes produce none.
- R10: A start pulse during a conversion discards all earlier state. The next result depends only on input received after that start, and no result is presented in the second cycle after a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion start; clears filter and accumulator |
| cont_i | input | 1 | 1 = continuous mode, 0 = one-shot mode |
| src_par_i | input | 1 | 1 = parallel input, 0 = serial bitstream |
| bypass_i | input | 1 | Parallel samples skip the filter (only with src_par_i = 1) |
| fastsinc_i | input | 1 | Select the fast second-order filter type |
| order_i | input | 3 | Sinc order 1..5 |
| osr_i | input | 10 | Decimation ratio D, 1..1023 |
| ior_i | input | 8 | Accumulation count K, 1..255 |
| shift_i | input | 5 | Arithmetic right shift of the result |
| bit_valid_i | input | 1 | Serial bit strobe |
| bit_i | input | 1 | Serial bit |
| par_valid_i | input | 1 | Parallel sample strobe |
| par_data_i | input | 24 | Signed parallel sample |
| sample_valid_o | output | 1 | Result valid pulse |
| sample_o | output | 24 | Signed result |

## Verification
Constant all-ones and all-zeros bitstreams go through sinc orders 1, 3 and 5 and through the fast filter. Because a settled constant input has a closed-form value of c·K·D^N, these runs check both the gain and the exact settling strobe count, and a wrong order, ratio or skip count shifts one of them. A constant negative parallel stream through the filter checks the parallel-path sign extension. Non-constant bypass sequences, including two large values that overflow 24 bits, check the accumulation order, the wrap, and the shift rounding toward minus infinity. Back-to-back bypass samples in continuous mode check that no sample is lost in the capture cycle. A start that interrupts a run of −1 bits, followed by +1 bits, shows whether stale state leaks into the next result.

// File: rtl/sd_decim_pkg.sv
package sd_decim_pkg;
  localparam int unsigned ACC_W   = 32;
  localparam int unsigned MAX_ORD = 5;
  localparam int unsigned PIPE_LAT = 3;

  typedef logic signed [ACC_W-1:0] acc_t;

  function automatic logic [2:0] eff_order(input logic [2:0] ord, input logic fast_sinc);
    if (fast_sinc) return 3'd2;
    if (ord == 3'd0) return 3'd1;
    if (ord > 3'(MAX_ORD)) return 3'(MAX_ORD);
    return ord;
  endfunction

  // decimated outputs dropped before accumulation starts
  function automatic logic [2:0] skip_cnt(input logic [2:0] ord, input logic fast_sinc);
    return fast_sinc ? 3'd3 : ord - 3'd1;
  endfunction

  // extra strobes before a one-shot result is presented
  function automatic logic [2:0] flush_cnt(input logic [2:0] ord, input logic fast_sinc);
    return fast_sinc ? 3'd3 : ord + 3'd1;
  endfunction
endpackage

// File: rtl/sd_cic.sv
module sd_cic
  import sd_decim_pkg::*;
#(
  parameter int unsigned OSR_W = 10,
  parameter int unsigned ORD_N = MAX_ORD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             vld_i,
  input  acc_t             x_i,
  input  logic [OSR_W-1:0] osr_i,
  input  logic [2:0]       ord_i,
  output acc_t             y_o,
  output logic             y_vld_o
);
  acc_t integ_q [ORD_N];
  acc_t integ_d [ORD_N];
  acc_t dly_q   [ORD_N];
  acc_t comb_c  [ORD_N+1];
  acc_t tap, samp_q, comb_sel, y_q;
  logic [OSR_W-1:0] ph_q, ph_nx;
  logic dec_q, y_vld_q, wrap;

  always_comb begin
    integ_d[0] = integ_q[0] + x_i;
    for (int i = 1; i < ORD_N; i++) integ_d[i] = integ_q[i] + integ_d[i-1];
    tap = integ_d[0];
    for (int i = 0; i < ORD_N; i++) if (ord_i == 3'(i+1)) tap = integ_d[i];
  end

  assign ph_nx = ph_q + 1'b1;
  assign wrap  = (ph_nx == osr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ORD_N; i++) integ_q[i] <= '0;
      ph_q   <= '0;
      dec_q  <= 1'b0;
      samp_q <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < ORD_N; i++) integ_q[i] <= '0;
      ph_q   <= '0;
      dec_q  <= 1'b0;
      samp_q <= '0;
    end else begin
      dec_q <= vld_i & wrap;
      if (vld_i) begin
        for (int i = 0; i < ORD_N; i++) integ_q[i] <= integ_d[i];
        ph_q <= wrap ? '0 : ph_nx;
        if (wrap) samp_q <= tap;
      end
    end
  end

  // comb chain at the decimated rate
  always_comb begin
    comb_c[0] = samp_q;
    for (int j = 0; j < ORD_N; j++) comb_c[j+1] = comb_c[j] - dly_q[j];
    comb_sel = comb_c[1];
    for (int j = 0; j < ORD_N; j++) if (ord_i == 3'(j+1)) comb_sel = comb_c[j+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < ORD_N; j++) dly_q[j] <= '0;
      y_q     <= '0;
      y_vld_q <= 1'b0;
    end else if (clr_i) begin
      for (int j = 0; j < ORD_N; j++) dly_q[j] <= '0;
      y_q     <= '0;
      y_vld_q <= 1'b0;
    end else begin
      y_vld_q <= dec_q;
      if (dec_q) begin
        for (int j = 0; j < ORD_N; j++) dly_q[j] <= comb_c[j];
        y_q <= comb_sel;
      end
    end
  end

  assign y_o     = y_q;
  assign y_vld_o = y_vld_q;
endmodule

// File: rtl/sd_intg.sv
module sd_intg
  import sd_decim_pkg::*;
#(
  parameter int unsigned IOR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             in_vld_i,
  input  acc_t             in_i,
  input  logic [2:0]       skip_i,
  input  logic [IOR_W-1:0] ior_i,
  input  logic             cont_i,
  input  logic             auto_cap_i,
  output acc_t             acc_o,
  output logic             cap_o
);
  logic [IOR_W-1:0] cnt_q, cnt_nx;
  logic [2:0] skip_q;
  logic armed_q, cap_q, take, drop, last, restart;
  acc_t acc_q;

  assign take    = armed_q & in_vld_i & (skip_q == skip_i);
  assign drop    = armed_q & in_vld_i & (skip_q != skip_i);
  assign cnt_nx  = cnt_q + 1'b1;
  assign last    = take & (cnt_nx == ior_i);
  assign restart = cap_q & cont_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      skip_q  <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      cap_q   <= 1'b0;
    end else if (clr_i) begin
      armed_q <= 1'b1;
      skip_q  <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      cap_q   <= 1'b0;
    end else begin
      cap_q <= last & auto_cap_i;
      if (drop) skip_q <= skip_q + 1'b1;
      if (take) begin
        acc_q <= (restart ? '0 : acc_q) + in_i;
        cnt_q <= last ? '0 : cnt_nx;
        if (last && !cont_i) armed_q <= 1'b0;
      end else if (restart) begin
        acc_q <= '0;
      end
    end
  end

  assign acc_o = acc_q;
  assign cap_o = cap_q;
endmodule

// File: rtl/sd_conv_ctrl.sv
module sd_conv_ctrl
  import sd_decim_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic [CNT_W-1:0] total_i,
  output logic             trig_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [PIPE_LAT-1:0] trig_q;
  logic act_q, hit;

  assign cnt_nx = cnt_q + 1'b1;
  assign hit    = act_q & en_i & vld_i & (cnt_nx == total_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      trig_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      cnt_q  <= '0;
      trig_q <= '0;
    end else begin
      trig_q <= {trig_q[PIPE_LAT-2:0], hit};
      if (act_q && en_i && vld_i) begin
        cnt_q <= cnt_nx;
        if (hit) act_q <= 1'b0;
      end
    end
  end

  assign trig_o = trig_q[PIPE_LAT-1];
endmodule

// File: rtl/sd_decim.sv
module sd_decim
  import sd_decim_pkg::*;
#(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OSR_W = 10,
  parameter int unsigned IOR_W = 8,
  parameter int unsigned SH_W  = 5,
  parameter int unsigned OUT_W = 24
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   cont_i,
  input  logic                   src_par_i,
  input  logic                   bypass_i,
  input  logic                   fastsinc_i,
  input  logic [2:0]             order_i,
  input  logic [OSR_W-1:0]       osr_i,
  input  logic [IOR_W-1:0]       ior_i,
  input  logic [SH_W-1:0]        shift_i,
  input  logic                   bit_valid_i,
  input  logic                   bit_i,
  input  logic                   par_valid_i,
  input  logic signed [IN_W-1:0] par_data_i,
  output logic                   sample_valid_o,
  output logic [OUT_W-1:0]       sample_o
);
  localparam int unsigned CNT_W = OSR_W + IOR_W + 2;

  logic [2:0] ord, skip, flush;
  logic in_vld, byp, use_cnt, trig, acc_cap, cap, y_vld, b1_v, b2_v, a_vld;
  logic [CNT_W-1:0] total;
  acc_t x, y, b1_q, b2_q, a_in, acc;
  logic [OUT_W-1:0] sample_q;
  logic valid_q;

  assign ord     = eff_order(order_i, fastsinc_i);
  assign skip    = skip_cnt(ord, fastsinc_i);
  assign flush   = flush_cnt(ord, fastsinc_i);
  assign byp     = src_par_i & bypass_i;
  assign use_cnt = ~cont_i & ~byp;
  assign in_vld  = src_par_i ? par_valid_i : bit_valid_i;
  assign x       = src_par_i ? ACC_W'(par_data_i) : (bit_i ? acc_t'(1) : acc_t'(-1));
  assign total   = CNT_W'(osr_i) * (CNT_W'(ior_i) + CNT_W'(skip)) + CNT_W'(flush);

  sd_cic #(.OSR_W(OSR_W), .ORD_N(MAX_ORD)) u_cic (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .vld_i  (in_vld & ~byp),
    .x_i    (x),
    .osr_i  (osr_i),
    .ord_i  (ord),
    .y_o    (y),
    .y_vld_o(y_vld)
  );

  // bypass samples matched to the filter's two-stage latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b1_q <= '0; b1_v <= 1'b0; b2_q <= '0; b2_v <= 1'b0;
    end else if (start_i) begin
      b1_q <= '0; b1_v <= 1'b0; b2_q <= '0; b2_v <= 1'b0;
    end else begin
      b1_q <= x;    b1_v <= in_vld & byp;
      b2_q <= b1_q; b2_v <= b1_v;
    end
  end

  assign a_in  = byp ? b2_q : y;
  assign a_vld = byp ? b2_v : y_vld;

  sd_intg #(.IOR_W(IOR_W)) u_intg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_i),
    .in_vld_i  (a_vld),
    .in_i      (a_in),
    .skip_i    (byp ? 3'd0 : skip),
    .ior_i     (ior_i),
    .cont_i    (cont_i),
    .auto_cap_i(~use_cnt),
    .acc_o     (acc),
    .cap_o     (acc_cap)
  );

  sd_conv_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .en_i   (use_cnt),
    .vld_i  (in_vld),
    .total_i(total),
    .trig_o (trig)
  );

  assign cap = use_cnt ? trig : acc_cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= cap;
      if (cap) sample_q <= OUT_W'(acc >>> shift_i);
    end
  end

  assign sample_o       = sample_q;
  assign sample_valid_o = valid_q;
endmodule

// File: rtl/sd_decim_chk.sv
module sd_decim_chk #(
  parameter int unsigned SH_W  = 5,
  parameter int unsigned OUT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             cont_i,
  input logic [SH_W-1:0]  shift_i,
  input logic             sample_valid_o,
  input logic [OUT_W-1:0] sample_o
);
  logic started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else if (start_i) started_q <= 1'b1;
  end

  AST_NO_EARLY_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> !sample_valid_o); // R9

  AST_ONE_SHOT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cont_i && sample_valid_o) |=> !sample_valid_o); // R8

  AST_HOLD_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_o |-> $stable(sample_o)); // R8

  AST_START_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ##1 !sample_valid_o); // R10

  AST_SHIFT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_o && $past(shift_i) == SH_W'(31)) |-> (sample_o == '0 || &sample_o)); // R7
endmodule

bind sd_decim sd_decim_chk #(.SH_W(SH_W), .OUT_W(OUT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .cont_i        (cont_i),
  .shift_i       (shift_i),
  .sample_valid_o(sample_valid_o),
  .sample_o      (sample_o)
);

// File: tb/sd_decim_test.sv
module sd_decim_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, cont = 0, src_par = 0, bypass = 0, fastsinc = 0;
  logic [2:0] order = 3'd1;
  logic [9:0] osr = 10'd1;
  logic [7:0] ior = 8'd1;
  logic [4:0] shift = '0;
  logic bit_valid = 0, bit_in = 0, par_valid = 0;
  logic signed [23:0] par_data = '0;
  logic sample_valid;
  logic [23:0] sample;

  int cyc = 0, nchk = 0, nfail = 0, lidx = 0, scount = 0;
  int lv_cyc [16];
  logic [23:0] lv_val [16];
  int s_cyc [4096];
  bit done = 0;

  sd_decim uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cont_i(cont), .src_par_i(src_par),
    .bypass_i(bypass), .fastsinc_i(fastsinc), .order_i(order), .osr_i(osr), .ior_i(ior),
    .shift_i(shift), .bit_valid_i(bit_valid), .bit_i(bit_in), .par_valid_i(par_valid),
    .par_data_i(par_data), .sample_valid_o(sample_valid), .sample_o(sample)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (sample_valid) begin
    if (lidx < 16) begin lv_cyc[lidx] = cyc; lv_val[lidx] = sample; end
    lidx++;
  end

  task automatic check(input bit ok, input string msg, input longint act, input longint exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s actual=%0h expected=%0h", msg, act, exp); end
  endtask

  function automatic logic [23:0] exp24(input longint v, input int sh);
    logic signed [31:0] t;
    t = 32'(v);
    t = t >>> sh;
    return t[23:0];
  endfunction

  task automatic set_cfg(input bit c, input bit sp, input bit bp, input bit fs,
                         input int o, input int d, input int k, input int sh);
    @(negedge clk);
    cont = c; src_par = sp; bypass = bp; fastsinc = fs;
    order = 3'(o); osr = 10'(d); ior = 8'(k); shift = 5'(sh);
  endtask

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    scount = 0; lidx = 0;
  endtask

  task automatic feed_bits(input int n, input bit b, input int gap);
    for (int k = 0; k < n; k++) begin
      bit_valid = 1; bit_in = b;
      @(negedge clk);
      s_cyc[scount] = cyc; scount++;
      if (gap > 0) begin bit_valid = 0; repeat (gap) @(negedge clk); end
    end
    bit_valid = 0;
  endtask

  task automatic feed_par(input int v, input int gap);
    par_valid = 1; par_data = 24'(v);
    @(negedge clk);
    s_cyc[scount] = cyc; scount++;
    par_valid = 0;
    if (gap > 0) repeat (gap) @(negedge clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // one-shot result: count, timing and value
  task automatic expect_one(input string tag, input int total, input longint val, input int sh);
    check(lidx == 1, {tag, " result count"}, lidx, 1);
    check(lv_cyc[0] == s_cyc[total-1] + 3, {tag, " timing"}, lv_cyc[0], s_cyc[total-1] + 3);
    check(lv_val[0] == exp24(val, sh), {tag, " value"}, lv_val[0], exp24(val, sh));
  endtask

  task automatic t_reset();
    check(sample === 24'h0, "R9 reset sample", sample, 0);
    check(sample_valid === 1'b0, "R9 reset valid", sample_valid, 0);
    set_cfg(0, 0, 0, 0, 1, 2, 1, 0);
    lidx = 0; scount = 0;
    feed_bits(30, 1, 0); settle();
    check(lidx == 0, "R9 no output before start", lidx, 0);
  endtask

  task automatic t_sinc3_pos();  // R1 R2
    set_cfg(0, 0, 0, 0, 3, 4, 2, 0); do_start();
    feed_bits(20, 1, 0); settle();
    expect_one("R1 R2 sinc3", 20, 2 * 64, 0);
    feed_bits(10, 1, 0); settle();
    check(lidx == 1, "R9 one result per start", lidx, 1);
  endtask

  task automatic t_sinc5_neg();  // R1 R2 R7
    set_cfg(0, 0, 0, 0, 5, 3, 3, 2); do_start();
    feed_bits(27, 0, 0); settle();
    expect_one("R1 R7 sinc5 negative", 27, -729, 2);
  endtask

  task automatic t_sinc1_gap();  // R2
    set_cfg(0, 0, 0, 0, 1, 8, 1, 0); do_start();
    feed_bits(10, 1, 2); settle();
    expect_one("R2 sinc1 gapped", 10, 8, 0);
  endtask

  task automatic t_fastsinc();  // R3
    set_cfg(0, 0, 0, 1, 5, 5, 2, 0); do_start();
    feed_bits(28, 1, 0); settle();
    expect_one("R3 fastsinc", 28, 50, 0);
  endtask

  task automatic t_cont();  // R4
    set_cfg(1, 0, 0, 0, 2, 4, 3, 0); do_start();
    feed_bits(40, 1, 0); settle();
    check(lidx == 3, "R4 continuous count", lidx, 3);
    for (int r = 0; r < 3; r++) begin
      check(lv_cyc[r] == s_cyc[15 + 12*r] + 3, "R4 continuous timing", lv_cyc[r], s_cyc[15 + 12*r] + 3);
      check(lv_val[r] == exp24(48, 0), "R4 continuous value", lv_val[r], 48);
    end
  endtask

  task automatic t_par_filt();  // R5
    set_cfg(0, 1, 0, 0, 2, 4, 2, 0); do_start();
    for (int k = 0; k < 15; k++) feed_par(-1000, 0);
    settle();
    expect_one("R5 parallel filtered", 15, -32000, 0);
  endtask

  task automatic t_bypass_once();  // R6 R9
    set_cfg(0, 1, 1, 0, 1, 1, 4, 1); do_start();
    feed_par(100, 1); feed_par(-30, 1); feed_par(7, 1); feed_par(2000, 1);
    settle();
    expect_one("R6 bypass one-shot", 4, 2077, 1);
    feed_par(50, 0); feed_par(60, 0); settle();
    check(lidx == 1, "R9 bypass one per start", lidx, 1);
  endtask

  task automatic t_bypass_cont();  // R6 R7
    set_cfg(1, 1, 1, 0, 1, 1, 2, 0); do_start();
    feed_par(24'h700000, 0); feed_par(24'h700000, 0); feed_par(-5, 0); feed_par(-6, 0);
    settle();
    check(lidx == 2, "R6 bypass continuous count", lidx, 2);
    check(lv_cyc[0] == s_cyc[1] + 3, "R6 bypass timing", lv_cyc[0], s_cyc[1] + 3);
    check(lv_cyc[1] == s_cyc[3] + 3, "R6 bypass timing", lv_cyc[1], s_cyc[3] + 3);
    check(lv_val[0] == 24'hE00000, "R7 wrap to 24 bits", lv_val[0], 24'hE00000);
    check(lv_val[1] == 24'hFFFFF5, "R6 back-to-back sum", lv_val[1], 24'hFFFFF5);
  endtask

  task automatic t_shift31();  // R7
    set_cfg(0, 1, 1, 0, 1, 1, 1, 31); do_start();
    feed_par(-1, 0); settle();
    expect_one("R7 shift31 negative", 1, -1, 31);
    do_start();
    feed_par(5, 0); settle();
    expect_one("R7 shift31 positive", 1, 5, 31);
  endtask

  task automatic t_restart();  // R10
    set_cfg(0, 0, 0, 0, 1, 4, 1, 0); do_start();
    feed_bits(3, 0, 0);
    do_start();
    feed_bits(6, 1, 0); settle();
    expect_one("R10 restart", 6, 4, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sinc3_pos();
    t_sinc5_neg();
    t_sinc1_gap();
    t_fastsinc();
    t_cont();
    t_par_filt();
    t_bypass_once();
    t_bypass_cont();
    t_shift31();
    t_restart();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end
endmodule